// File: doc/BRIEF.md
# Golden-Priority Deflection Port Allocator

This block assigns output ports inside a bufferless deflection router. Each cycle up to four flits arrive on four internal channels. Each flit carries a valid bit, a packet identifier, a desired output port and a payload. Every valid flit leaves on a distinct output port, so nothing is held back and nothing is lost. A flit whose packet identifier equals the current golden identifier is marked golden and always reaches the port it asked for. This guarantee is what keeps the network free of livelock. All other contention is settled by coin flips taken from a free-running LFSR. A flit that loses goes out on whichever port is left over and is flagged as deflected.

Allocation is done in parallel by a two-stage network of 2x2 arbiters. In the first stage, each arbiter sends its winner toward the half of the ports that holds the winner's target. In the second stage, each arbiter picks the exact port inside that half. A register follows each stage, so results appear two clock edges after the inputs are captured. The golden identifier advances by one every `EPOCH` cycles after reset, so every packet eventually becomes golden.

Top module: `defl_permuter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every output valid bit, golden mark and deflect flag is 0. The golden identifier restarts at 0.
- R2: A flit presented to the inputs before clock edge k appears on the outputs after edge k+1. Flits on consecutive cycles stream through without interfering.
- R3: Every valid input flit leaves on exactly one output port with its packet identifier, desired port and payload unchanged. The number of valid outputs equals the number of valid inputs. A channel whose valid bit is 0 never occupies an output.
- R4: A flit is golden when it is valid and its packet identifier equals the golden identifier. When exactly one golden flit is present, it leaves on output port number `dir`, whatever the other flits request.
- R5: The golden identifier is 0 after reset. It increases by one, modulo 2^PID_W, after every EPOCH clock edges with reset low. The golden identifier in force when a flit is sampled is floor(n/EPOCH) mod 2^PID_W, where n is the number of edges with reset low since reset.
- R6: A flit that is the only valid flit in its cycle always leaves on its desired port and is not deflected.
- R7: The deflect flag of output j is 1 exactly when output j is valid and the flit on it asked for a port other than j. Port numbers 0 to 3 are the output indices, and bit 1 of the port number selects the half.
- R8: When two flits want the same port and one of them is golden, the golden flit gets the port. The other flit leaves on a different port with its deflect flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Valid bit per input channel |
| in_pid | input | 4*PID_W | Packet identifier per channel, channel c at bits c*PID_W |
| in_dir | input | 8 | Desired output port per channel, 2 bits each |
| in_data | input | 4*DATA_W | Payload per channel |
| out_valid | output | 4 | Valid bit per output port |
| out_pid | output | 4*PID_W | Packet identifier on each output port |
| out_dir | output | 8 | Desired port of the flit on each output |
| out_data | output | 4*DATA_W | Payload on each output port |
| out_golden | output | 4 | Golden mark of the flit on each output |
| out_deflect | output | 4 | Set when the flit on the port is not on its desired port |

## Verification
Every result is due exactly two clock edges after the inputs are captured. The bench drives inputs on a falling edge and returns the inputs to idle on the next falling edge. At that point it confirms that nothing has reached the outputs yet. It compares all outputs on the falling edge after that. The bench predicts the golden identifier by counting edges with reset low since reset. Because non-golden winners depend on the LFSR, the bench does not check exact ports for them. It checks the invariants instead: conservation, the golden flit's port, productive routing of a lone flit, and the deflect flags. A back-to-back test sends two flits on consecutive cycles and expects each one on its own output cycle.

// File: rtl/defl_pkg.sv
package defl_pkg;

    localparam int NCH       = 4;
    localparam int PORT_W    = $clog2(NCH);
    localparam int PID_W     = 4;
    localparam int DATA_W    = 16;
    localparam int LFSR_W    = 16;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

    typedef logic [PORT_W-1:0] port_t;

    typedef struct packed {
        logic              valid;
        logic              golden;
        logic [PID_W-1:0]  pid;
        port_t             dir;
        logic [DATA_W-1:0] data;
    } flit_t;

    // Priority order: valid over empty, golden over ordinary, then coin.
    function automatic logic first_wins(flit_t a, flit_t b, logic coin);
        if (a.valid != b.valid)   return a.valid;
        if (a.golden != b.golden) return a.golden;
        return coin;
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_step(logic [LFSR_W-1:0] s);
        return (s >> 1) ^ (s[0] ? LFSR_TAPS : '0);
    endfunction

endpackage

// File: rtl/defl_arb2x2.sv
module defl_arb2x2
    import defl_pkg::*;
#(
    parameter int SEL_BIT = 0
) (
    input  flit_t a,
    input  flit_t b,
    input  logic  coin,
    output flit_t o0,
    output flit_t o1
);
    logic a_wins;
    logic swap;

    always_comb begin
        a_wins = first_wins(a, b, coin);
        // Winner goes to the side named by its steering bit.
        swap   = a_wins ? a.dir[SEL_BIT] : ~b.dir[SEL_BIT];
        o0     = swap ? b : a;
        o1     = swap ? a : b;
    end
endmodule

// File: rtl/defl_prio_gen.sv
module defl_prio_gen
    import defl_pkg::*;
#(
    parameter int                EPOCH = 256,
    parameter logic [LFSR_W-1:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [PID_W-1:0] golden_id,
    output logic [NCH-1:0]   coins
);
    localparam int CNT_W = (EPOCH > 1) ? $clog2(EPOCH) : 1;

    logic [CNT_W-1:0]  epoch_cnt;
    logic [LFSR_W-1:0] lfsr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            epoch_cnt <= '0;
            golden_id <= '0;
            lfsr_q    <= SEED;
        end else begin
            lfsr_q <= lfsr_step(lfsr_q);
            if (epoch_cnt == CNT_W'(EPOCH - 1)) begin
                epoch_cnt <= '0;
                golden_id <= golden_id + 1'b1;
            end else begin
                epoch_cnt <= epoch_cnt + 1'b1;
            end
        end
    end

    assign coins = lfsr_q[NCH-1:0] ^ lfsr_q[LFSR_W-1 -: NCH];
endmodule

// File: rtl/defl_permuter.sv
module defl_permuter
    import defl_pkg::*;
#(
    parameter int                EPOCH     = 256,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        in_valid,
    input  logic [NCH*PID_W-1:0]  in_pid,
    input  logic [NCH*PORT_W-1:0] in_dir,
    input  logic [NCH*DATA_W-1:0] in_data,
    output logic [NCH-1:0]        out_valid,
    output logic [NCH*PID_W-1:0]  out_pid,
    output logic [NCH*PORT_W-1:0] out_dir,
    output logic [NCH*DATA_W-1:0] out_data,
    output logic [NCH-1:0]        out_golden,
    output logic [NCH-1:0]        out_deflect
);
    localparam int HALF = NCH / 2;

    logic [PID_W-1:0] golden_id;
    logic [NCH-1:0]   coins;

    flit_t in_f [NCH];
    flit_t s1_d [NCH];
    flit_t s1_q [NCH];
    flit_t s2_d [NCH];
    flit_t out_q [NCH];
    logic [NCH-1:0] defl_q;

    defl_prio_gen #(.EPOCH(EPOCH), .SEED(LFSR_SEED)) u_prio (
        .clk(clk), .rst(rst), .golden_id(golden_id), .coins(coins)
    );

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            in_f[c].valid  = in_valid[c];
            in_f[c].pid    = in_pid[c*PID_W +: PID_W];
            in_f[c].dir    = in_dir[c*PORT_W +: PORT_W];
            in_f[c].data   = in_data[c*DATA_W +: DATA_W];
            in_f[c].golden = in_valid[c] && (in_pid[c*PID_W +: PID_W] == golden_id);
        end
    end

    // Stage 1: pick the half. Block k pairs channels k and k+HALF.
    // Stage 2: pick the port inside half h.
    for (genvar k = 0; k < HALF; k++) begin : g_stage
        defl_arb2x2 #(.SEL_BIT(PORT_W-1)) u_half (
            .a(in_f[k]), .b(in_f[k+HALF]), .coin(coins[k]),
            .o0(s1_d[k*2]), .o1(s1_d[k*2+1])
        );
        defl_arb2x2 #(.SEL_BIT(0)) u_port (
            .a(s1_q[0*2+k]), .b(s1_q[1*2+k]), .coin(coins[HALF+k]),
            .o0(s2_d[k*2]), .o1(s2_d[k*2+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                s1_q[c]  <= '0;
                out_q[c] <= '0;
            end
            defl_q <= '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                s1_q[c]   <= s1_d[c];
                out_q[c]  <= s2_d[c];
                defl_q[c] <= s2_d[c].valid && (s2_d[c].dir != port_t'(c));
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            out_valid[c]                   = out_q[c].valid;
            out_golden[c]                  = out_q[c].golden;
            out_pid[c*PID_W +: PID_W]      = out_q[c].pid;
            out_dir[c*PORT_W +: PORT_W]    = out_q[c].dir;
            out_data[c*DATA_W +: DATA_W]   = out_q[c].data;
        end
    end
    assign out_deflect = defl_q;
endmodule

// File: rtl/defl_permuter_chk.sv
module defl_permuter_chk
    import defl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NCH-1:0]   in_valid,
    input logic [NCH-1:0]   out_valid,
    input logic [NCH-1:0]   out_golden,
    input logic [NCH-1:0]   out_deflect,
    input logic [PID_W-1:0] gid
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)           age <= '0;
        else if (age != 2) age <= age + 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_valid == '0 && out_deflect == '0));

    p_conserve_r3: assert property (@(posedge clk) disable iff (rst)
        (age == 2) |-> ($countones(out_valid) == $past($countones(in_valid), 2)));

    p_golden_port_r4: assert property (@(posedge clk) disable iff (rst)
        ($countones(out_golden) == 1) |-> ((out_golden & out_deflect) == '0));

    p_gid_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(gid)) |-> (gid == PID_W'($past(gid) + 1)));

    p_lone_r6: assert property (@(posedge clk) disable iff (rst)
        (age == 2 && $past($countones(in_valid), 2) == 1) |-> (out_deflect == '0));

    p_defl_valid_r7: assert property (@(posedge clk) disable iff (rst)
        (out_deflect & ~out_valid) == '0);
endmodule

bind defl_permuter defl_permuter_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .out_golden(out_golden), .out_deflect(out_deflect), .gid(golden_id)
);

// File: tb/tb_defl_permuter.sv
module tb_defl_permuter;
    import defl_pkg::*;

    localparam int EPOCH = 8;
    localparam int NV    = 13;
    // {valid mask[14:11], dirs ch3..ch0 [10:3], golden channel [2:0] (4 = none)}
    localparam logic [14:0] VEC [NV] = '{
        {4'b1111, 8'b00_00_00_00, 3'd0},
        {4'b1111, 8'b11_10_01_00, 3'd2},
        {4'b1111, 8'b11_11_11_11, 3'd3},
        {4'b0001, 8'b00_00_00_10, 3'd4},
        {4'b0100, 8'b00_01_00_00, 3'd4},
        {4'b1000, 8'b11_00_00_00, 3'd3},
        {4'b0011, 8'b00_00_01_01, 3'd1},
        {4'b1010, 8'b10_00_10_00, 3'd1},
        {4'b0101, 8'b00_11_00_00, 3'd4},
        {4'b1110, 8'b00_10_10_00, 3'd2},
        {4'b0000, 8'b00_00_00_00, 3'd4},
        {4'b1111, 8'b01_01_01_01, 3'd1},
        {4'b1111, 8'b00_01_10_11, 3'd0}
    };

    logic clk = 0, rst = 1;
    logic [NCH-1:0]        in_valid = '0;
    logic [NCH*PID_W-1:0]  in_pid = '0;
    logic [NCH*PORT_W-1:0] in_dir = '0;
    logic [NCH*DATA_W-1:0] in_data = '0;
    logic [NCH-1:0]        out_valid, out_golden, out_deflect;
    logic [NCH*PID_W-1:0]  out_pid;
    logic [NCH*PORT_W-1:0] out_dir;
    logic [NCH*DATA_W-1:0] out_data;

    int checks = 0, failures = 0, ncyc = 0, seq = 0;
    bit done = 0;

    logic [NCH-1:0]    e_mask;
    logic [PORT_W-1:0] e_dir  [NCH];
    logic [PID_W-1:0]  e_pid  [NCH];
    logic [DATA_W-1:0] e_data [NCH];
    int                e_g;

    defl_permuter #(.EPOCH(EPOCH)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pid(in_pid), .in_dir(in_dir),
        .in_data(in_data), .out_valid(out_valid), .out_pid(out_pid), .out_dir(out_dir),
        .out_data(out_data), .out_golden(out_golden), .out_deflect(out_deflect)
    );

    always #5 clk = ~clk;

    // Golden identifier model (R5): edges with reset low since reset.
    always @(posedge clk) begin
        if (rst) ncyc <= 0;
        else     ncyc <= ncyc + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [NCH-1:0] mask, input logic [7:0] dirs, input int g);
        int gid;
        gid = (ncyc / EPOCH) % (1 << PID_W);
        seq++;
        e_mask = mask;
        e_g    = g;
        for (int c = 0; c < NCH; c++) begin
            e_dir[c]  = dirs[c*2 +: 2];
            e_pid[c]  = (c == g) ? PID_W'(gid) : PID_W'(gid + 1 + c);
            e_data[c] = {seq[11:0], 4'(c)};
            in_dir[c*PORT_W +: PORT_W]  = e_dir[c];
            in_pid[c*PID_W +: PID_W]    = e_pid[c];
            in_data[c*DATA_W +: DATA_W] = e_data[c];
        end
        in_valid = mask;
    endtask

    task automatic idle();
        in_valid = '0;
    endtask

    task automatic verify(input string tag);
        int nv, found, exp_def;
        nv = $countones(out_valid);
        chk(nv == $countones(e_mask), "R3", {tag, " valid count"}, nv, $countones(e_mask));
        for (int c = 0; c < NCH; c++) begin
            if (e_mask[c]) begin
                found = 0;
                for (int j = 0; j < NCH; j++)
                    if (out_valid[j] && out_pid[j*PID_W +: PID_W] == e_pid[c] &&
                        out_data[j*DATA_W +: DATA_W] == e_data[c] &&
                        out_dir[j*PORT_W +: PORT_W] == e_dir[c])
                        found++;
                chk(found == 1, "R3", {tag, " flit copies"}, found, 1);
            end
        end
        for (int j = 0; j < NCH; j++) begin
            exp_def = (out_valid[j] && out_dir[j*PORT_W +: PORT_W] != PORT_W'(j)) ? 1 : 0;
            chk(out_deflect[j] == exp_def[0], "R7", {tag, " deflect flag"}, out_deflect[j], exp_def);
        end
        if (e_g < NCH && e_mask[e_g]) begin
            chk(out_valid[e_dir[e_g]] && out_data[e_dir[e_g]*DATA_W +: DATA_W] == e_data[e_g],
                "R4", {tag, " golden on its port"}, out_data[e_dir[e_g]*DATA_W +: DATA_W], e_data[e_g]);
            chk(out_golden == (4'b1 << e_dir[e_g]), "R8", {tag, " golden mark"},
                out_golden, 4'b1 << e_dir[e_g]);
        end
        if ($countones(e_mask) == 1)
            chk(out_deflect == '0, "R6", {tag, " lone flit deflected"}, out_deflect, 0);
    endtask

    task automatic run_vec(input logic [14:0] v, input string tag);
        drive(v[14:11], v[10:3], int'(v[2:0]));
        @(negedge clk);
        idle();
        chk(out_valid == '0, "R2", {tag, " output too early"}, out_valid, 0);
        @(negedge clk);
        verify(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == '0 && out_deflect == '0 && out_golden == '0, "R1", "during reset",
            {out_valid, out_deflect}, 0);
        rst = 0;
        @(negedge clk);
        chk(out_valid == '0, "R1", "after reset", out_valid, 0);

        // Table walked several times so golden id and LFSR take many values.
        for (int pass = 0; pass < 4; pass++)
            for (int i = 0; i < NV; i++)
                run_vec(VEC[i], $sformatf("vec%0d.%0d", pass, i));

        // R8: two flits contend for port 2, golden one wins, other deflected.
        drive(4'b0101, 8'b00_10_00_10, 2);
        @(negedge clk); idle();
        @(negedge clk);
        chk(out_data[2*DATA_W +: DATA_W] == e_data[2], "R8", "golden holds port 2",
            out_data[2*DATA_W +: DATA_W], e_data[2]);
        chk($countones(out_deflect) == 1 && !out_deflect[2], "R8", "loser deflected",
            out_deflect, 0);

        // R2: back-to-back lone flits stream through on consecutive cycles.
        drive(4'b0001, 8'b00_00_00_01, 4);
        @(negedge clk);
        drive(4'b1000, 8'b10_00_00_00, 4);
        @(negedge clk);
        idle();
        chk(out_valid == 4'b0010 && out_deflect == '0, "R2", "first of pair on port 1",
            out_valid, 4'b0010);
        @(negedge clk);
        chk(out_valid == 4'b0100 && out_deflect == '0, "R2", "second of pair on port 2",
            out_valid, 4'b0100);

        // R5: run across the identifier wrap, then contend with the predicted golden flit.
        repeat ((1 << PID_W) * EPOCH + 3) @(negedge clk);
        run_vec(VEC[0], "R5 after wrap");
        run_vec(VEC[12], "R5 after wrap b");

        // R1: reset in the middle of traffic clears outputs and golden id.
        drive(4'b1111, 8'b00_00_00_00, 1);
        @(negedge clk);
        idle();
        rst = 1;
        @(negedge clk);
        chk(out_valid == '0 && out_deflect == '0, "R1", "mid-run reset", out_valid, 0);
        rst = 0;
        @(negedge clk);
        chk(out_valid == '0, "R1", "after mid-run reset", out_valid, 0);
        run_vec(VEC[1], "R5 restart at zero");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule